// File: doc/BRIEF.md
# Event and Cycle Counting Monitor

This block counts processor activity for profiling. It has one cycle counter and a parameterised number of event counters, four by default, all 32 bits wide. Each event counter is tied to one line of an incoming vector of single-cycle event pulses. The line is chosen by an 8-bit code. Software programs and reads the block through a simple register port: byte address, write strobe, write data and registered read data.

Control, overflow status, interrupt enables and event codes each have their own register. The status register and the enable register use the same bit order: the cycle counter is bit 0 and event counter k is bit k+1. When a counter wraps, it raises its sticky flag. The level interrupt is the OR of every flag that has its enable bit set.

Register map (byte addresses): 0x00 control, 0x04 overflow flags, 0x08 interrupt enables, 0x0C event codes, 0x10 cycle counter, 0x14 + 4k event counter k.

Top module: `evmon_unit`

## Requirements
- R1: After reset every counter, the flag register and the enable register read 0. The code register reads 0xFFFFFFFF (all counters off). Control reads only the ID byte in bits 31:24. `irq` is low.
- R2: A control write keeps only bit 0 (run) and bit 3 (divided cycle mode). Bits 4 to 31 have no effect. A control read returns run in bit 0, divided mode in bit 3 and the ID_CODE parameter in bits 31:24, with every other bit 0.
- R3: Event counter k uses the code in bits 8k+7:8k of the code register. It adds one on each clock edge where run is 1 and `ev_in[code]` is 1. Code 0xFF, or any code of NUM_SRC or more, never counts. With run at 0, no counter changes except by a bus write or a clear.
- R4: With run at 1, the cycle counter adds one on every edge in normal mode. In divided mode it adds one on every CYC_DIV-th run edge, counted by a prescaler that starts at zero.
- R5: A control write with bit 1 set zeroes all event counters. A control write with bit 2 set zeroes the cycle counter and its prescaler. Neither bit is stored.
- R6: A counter that steps past 0xFFFFFFFF goes to 0 and sets its flag: bit 0 for the cycle counter, bit k+1 for event counter k.
- R7: Writing 1 to a flag bit clears it, and writing 0 leaves it as it is. If a wrap happens on the same edge as a clearing write, the flag stays set.
- R8: The enable register uses the flag bit order. `irq` is a register that goes high one edge after some flag and its enable bit are both 1, and goes low one edge after no such pair remains.
- R9: Any counter can be written through its address. On the same edge, a bus write takes priority over an increment.
- R10: `bus_rdata` shows, one edge later, the register addressed in the current cycle. An unmapped address reads 0, and writes to it change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| ev_in | input | NUM_SRC | Single-cycle event pulses |
| irq | output | 1 | Level interrupt |

## Verification
The bench builds the block with NUM_SRC = 12 and CYC_DIV = 8. A source count that is not a power of two puts codes 12 to 254 in the "out of range, never counts" class, which a padded or truncated index can get wrong. A short divider lets the divided cycle mode roll its prescaler twice within a few dozen cycles. Wraps are reached by writing counters close to all ones. One case lines up a wrap with a clearing write on the same edge, and another lines up a bus write with an increment.

// File: rtl/evmon_pkg.sv
package evmon_pkg;
  localparam int DATA_W = 32;
  localparam int CODE_W = 8;

  // register byte offsets
  localparam int OFS_CTRL = 'h00;
  localparam int OFS_OVF  = 'h04;
  localparam int OFS_IEN  = 'h08;
  localparam int OFS_SEL  = 'h0C;
  localparam int OFS_CYC  = 'h10;  // event counter k sits at OFS_CYC + 4*(k+1)

  // control bit positions
  localparam int B_RUN   = 0;
  localparam int B_EVCLR = 1;
  localparam int B_CYCLR = 2;
  localparam int B_DIV   = 3;

  localparam logic [CODE_W-1:0] CODE_OFF = 8'hFF;
endpackage

// File: rtl/evmon_counter.sv
module evmon_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         ld,
  input  logic [W-1:0] ld_val,
  input  logic         inc,
  output logic [W-1:0] cnt,
  output logic         wrap
);
  // a wrap only happens when the increment actually lands
  assign wrap = inc && !clr && !ld && (cnt == {W{1'b1}});

  always_ff @(posedge clk) begin
    if (rst)       cnt <= '0;
    else if (clr)  cnt <= '0;
    else if (ld)   cnt <= ld_val;
    else if (inc)  cnt <= cnt + 1'b1;
  end

  p_wrap_zero_r6: assert property (@(posedge clk) disable iff (rst)
    wrap |=> (cnt == '0));
  p_load_wins_r9: assert property (@(posedge clk) disable iff (rst)
    (ld && !clr) |=> (cnt == $past(ld_val)));
  p_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (!inc && !ld && !clr) |=> $stable(cnt));
endmodule

// File: rtl/evmon_flags.sv
module evmon_flags #(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set,
  input  logic         clr_we,
  input  logic [N-1:0] clr_mask,
  input  logic [N-1:0] ien,
  output logic [N-1:0] flags,
  output logic         irq
);
  logic [N-1:0] drop;
  assign drop = clr_we ? clr_mask : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      flags <= '0;
      irq   <= 1'b0;
    end else begin
      flags <= (flags & ~drop) | set;  // a new wrap outranks a clear
      irq   <= |(flags & ien);
    end
  end

  p_set_kept_r7: assert property (@(posedge clk) disable iff (rst)
    (|set) |=> ((flags & $past(set)) == $past(set)));
  p_clear_r7: assert property (@(posedge clk) disable iff (rst)
    (clr_we && set == '0) |=> ((flags & $past(clr_mask)) == '0));
  p_irq_hi_r8: assert property (@(posedge clk) disable iff (rst)
    (|(flags & ien)) |=> irq);
  p_irq_lo_r8: assert property (@(posedge clk) disable iff (rst)
    !(|(flags & ien)) |=> !irq);
endmodule

// File: rtl/evmon_unit.sv
module evmon_unit
  import evmon_pkg::*;
#(
  parameter int          NUM_EV  = 4,
  parameter int          NUM_SRC = 16,
  parameter int          CYC_DIV = 64,
  parameter int          ADDR_W  = 6,
  parameter logic [7:0]  ID_CODE = 8'hA5
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic               bus_wr,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic [DATA_W-1:0]  bus_rdata,
  input  logic [NUM_SRC-1:0] ev_in,
  output logic               irq
);
  localparam int NCTR  = NUM_EV + 1;
  localparam int PRE_W = (CYC_DIV > 1) ? $clog2(CYC_DIV) : 1;
  localparam int SEL_W = CODE_W * NUM_EV;

  logic              run_q, div_q;
  logic [PRE_W-1:0]  pre_q;
  logic [NCTR-1:0]   ien_q, ovf, inc, wrap, wr_cnt, ctr_clr;
  logic [SEL_W-1:0]  sel_q;
  logic [DATA_W-1:0] cnt [NCTR];
  logic [255:0]      ev_pad;
  logic              wr_ctrl, wr_ovf, wr_ien, wr_sel, ev_clr, cy_clr, pre_last;
  logic [DATA_W-1:0] rd_mux;
  logic              rd_hit;

  function automatic logic [ADDR_W-1:0] ofs(input int o);
    return ADDR_W'(o);
  endfunction

  assign wr_ctrl  = bus_wr && (bus_addr == ofs(OFS_CTRL));
  assign wr_ovf   = bus_wr && (bus_addr == ofs(OFS_OVF));
  assign wr_ien   = bus_wr && (bus_addr == ofs(OFS_IEN));
  assign wr_sel   = bus_wr && (bus_addr == ofs(OFS_SEL));
  assign ev_clr   = wr_ctrl && bus_wdata[B_EVCLR];
  assign cy_clr   = wr_ctrl && bus_wdata[B_CYCLR];
  assign pre_last = (pre_q == PRE_W'(CYC_DIV - 1));
  assign ev_pad   = 256'(ev_in);

  // cycle counter step: every run edge, or every CYC_DIV-th in divided mode
  assign inc[0]     = run_q && (!div_q || pre_last);
  assign ctr_clr[0] = cy_clr;

  genvar k;
  generate
    for (k = 0; k < NUM_EV; k++) begin : g_ev
      logic [CODE_W-1:0] code;
      assign code         = sel_q[CODE_W*k +: CODE_W];
      assign inc[k+1]     = run_q && (code != CODE_OFF) && (int'(code) < NUM_SRC) && ev_pad[code];
      assign ctr_clr[k+1] = ev_clr;
    end
    for (k = 0; k < NCTR; k++) begin : g_ctr
      assign wr_cnt[k] = bus_wr && (bus_addr == ofs(OFS_CYC + 4 * k));
      evmon_counter #(.W(DATA_W)) u_ctr (
        .clk    (clk),
        .rst    (rst),
        .clr    (ctr_clr[k]),
        .ld     (wr_cnt[k]),
        .ld_val (bus_wdata),
        .inc    (inc[k]),
        .cnt    (cnt[k]),
        .wrap   (wrap[k])
      );
    end
  endgenerate

  evmon_flags #(.N(NCTR)) u_flags (
    .clk      (clk),
    .rst      (rst),
    .set      (wrap),
    .clr_we   (wr_ovf),
    .clr_mask (bus_wdata[NCTR-1:0]),
    .ien      (ien_q),
    .flags    (ovf),
    .irq      (irq)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q <= 1'b0;
      div_q <= 1'b0;
      pre_q <= '0;
      ien_q <= '0;
      sel_q <= '1;
    end else begin
      if (wr_ctrl) begin
        run_q <= bus_wdata[B_RUN];
        div_q <= bus_wdata[B_DIV];
      end
      if (wr_ien) ien_q <= bus_wdata[NCTR-1:0];
      if (wr_sel) sel_q <= bus_wdata[SEL_W-1:0];
      if (cy_clr)                pre_q <= '0;
      else if (run_q && div_q)   pre_q <= pre_last ? '0 : pre_q + 1'b1;
    end
  end

  always_comb begin
    rd_mux = '0;
    rd_hit = 1'b1;
    if (bus_addr == ofs(OFS_CTRL))
      rd_mux = {ID_CODE, 20'b0, div_q, 2'b0, run_q};
    else if (bus_addr == ofs(OFS_OVF)) rd_mux = DATA_W'(ovf);
    else if (bus_addr == ofs(OFS_IEN)) rd_mux = DATA_W'(ien_q);
    else if (bus_addr == ofs(OFS_SEL)) rd_mux = DATA_W'(sel_q);
    else rd_hit = 1'b0;
    for (int i = 0; i < NCTR; i++) begin
      if (bus_addr == ofs(OFS_CYC + 4 * i)) begin
        rd_mux = cnt[i];
        rd_hit = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= rd_mux;
  end

  p_ctrl_view_r2: assert property (@(posedge clk) disable iff (rst)
    (bus_addr == ofs(OFS_CTRL)) |=>
      (bus_rdata[31:24] == ID_CODE && bus_rdata[23:4] == '0 && bus_rdata[2:1] == '0));
  p_unmapped_r10: assert property (@(posedge clk) disable iff (rst)
    !rd_hit |=> (bus_rdata == '0));
  p_stopped_r4: assert property (@(posedge clk) disable iff (rst)
    (!run_q && !wr_cnt[0] && !cy_clr) |=> $stable(cnt[0]));
endmodule

// File: tb/tb_evmon_unit.sv
`timescale 1ns/1ps
module tb_evmon_unit;
  localparam int NSRC = 12;
  localparam int DIV  = 8;
  localparam logic [7:0] ID = 8'hA5;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [5:0]  t_addr = '0;
  logic        t_wr = 1'b0;
  logic [31:0] t_wdata = '0;
  logic [31:0] t_rdata;
  logic [NSRC-1:0] t_ev = '0;
  logic        t_irq;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  evmon_unit #(.NUM_EV(4), .NUM_SRC(NSRC), .CYC_DIV(DIV), .ADDR_W(6), .ID_CODE(ID)) dut (
    .clk(clk), .rst(rst), .bus_addr(t_addr), .bus_wr(t_wr), .bus_wdata(t_wdata),
    .bus_rdata(t_rdata), .ev_in(t_ev), .irq(t_irq));

  // ---------------- behavioural reference ----------------
  logic [31:0] m_cnt [5];
  logic [4:0]  m_ovf, m_ien, m_inc, m_set, m_touch;
  logic [31:0] m_sel;
  logic        m_run, m_div, live = 0;
  int          m_pre;
  logic [31:0] exp_rdata;
  logic        exp_irq;
  logic [7:0]  m_code;

  function automatic logic [31:0] m_read(input logic [5:0] a);
    case (a)
      6'h00: return {ID, 20'b0, m_div, 2'b0, m_run};
      6'h04: return {27'b0, m_ovf};
      6'h08: return {27'b0, m_ien};
      6'h0C: return m_sel;
      6'h10: return m_cnt[0];
      6'h14: return m_cnt[1];
      6'h18: return m_cnt[2];
      6'h1C: return m_cnt[3];
      6'h20: return m_cnt[4];
      default: return 32'h0;
    endcase
  endfunction

  function automatic string tag_of(input logic [5:0] a);
    case (a)
      6'h00: return "R2";
      6'h04: return "R6";
      6'h08: return "R8";
      6'h0C, 6'h14, 6'h18, 6'h1C, 6'h20: return "R3";
      6'h10: return "R4";
      default: return "R10";
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < 5; k++) m_cnt[k] = '0;
      m_ovf = '0; m_ien = '0; m_sel = '1; m_run = 0; m_div = 0; m_pre = 0;
      exp_rdata = '0; exp_irq = 0; live = 0;
    end else begin
      live = 1;
      exp_rdata = m_read(t_addr);
      exp_irq   = |(m_ovf & m_ien);
      m_inc[0] = m_run && (!m_div || m_pre == DIV - 1);
      for (int k = 0; k < 4; k++) begin
        m_code = m_sel[8*k +: 8];
        m_inc[k+1] = m_run && m_code != 8'hFF && int'(m_code) < NSRC && t_ev[m_code];
      end
      m_touch = '0;
      for (int k = 0; k < 5; k++)
        if (t_wr && t_addr == 6'(16 + 4*k)) m_touch[k] = 1;
      if (t_wr && t_addr == 6'h00) begin
        if (t_wdata[1]) m_touch[4:1] = 4'hF;
        if (t_wdata[2]) m_touch[0] = 1;
      end
      m_set = m_inc & ~m_touch;
      for (int k = 0; k < 5; k++) m_set[k] = m_set[k] && (m_cnt[k] == 32'hFFFFFFFF);
      if (t_wr && t_addr == 6'h00 && t_wdata[2]) m_pre = 0;
      else if (m_run && m_div) m_pre = (m_pre == DIV - 1) ? 0 : m_pre + 1;
      for (int k = 0; k < 5; k++) begin
        if (t_wr && t_addr == 6'(16 + 4*k)) m_cnt[k] = t_wdata;
        else if (m_touch[k]) m_cnt[k] = '0;
        else if (m_inc[k]) m_cnt[k] = m_cnt[k] + 1;
      end
      m_ovf = m_ovf & ~((t_wr && t_addr == 6'h04) ? t_wdata[4:0] : 5'b0);
      m_ovf = m_ovf | m_set;
      if (t_wr && t_addr == 6'h08) m_ien = t_wdata[4:0];
      if (t_wr && t_addr == 6'h0C) m_sel = t_wdata;
      if (t_wr && t_addr == 6'h00) begin m_run = t_wdata[0]; m_div = t_wdata[3]; end
    end
  end

  logic [5:0] last_addr;
  always @(posedge clk) last_addr <= t_addr;

  always @(negedge clk) begin
    if (live && !done) begin
      n_chk++;
      if (t_rdata !== exp_rdata) begin
        n_fail++;
        $display("FAIL %s model rdata addr=%h actual=%h expected=%h", tag_of(last_addr), last_addr, t_rdata, exp_rdata);
      end
      n_chk++;
      if (t_irq !== exp_irq) begin
        n_fail++;
        $display("FAIL R8 model irq actual=%0b expected=%0b", t_irq, exp_irq);
      end
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    t_addr = a; t_wr = 1; t_wdata = d;
    @(negedge clk);
    t_wr = 0; t_wdata = '0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rd(input logic [5:0] a, input logic [31:0] e, input string tag);
    t_addr = a; t_wr = 0;
    @(negedge clk);
    n_chk++;
    if (t_rdata !== e) begin
      n_fail++;
      $display("FAIL %s read %h actual=%h expected=%h", tag, a, t_rdata, e);
    end
  endtask

  task automatic chk_irq(input logic e, input string tag);
    n_chk++;
    if (t_irq !== e) begin
      n_fail++;
      $display("FAIL %s irq actual=%0b expected=%0b", tag, t_irq, e);
    end
  endtask

  task automatic pulse(input logic [NSRC-1:0] m, input int n);
    t_ev = m;
    repeat (n) @(negedge clk);
    t_ev = '0;
  endtask

  task automatic finish_up();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(4 * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    chk_irq(1'b0, "R1");
    rd(6'h00, {ID, 24'h0}, "R1");
    rd(6'h0C, 32'hFFFFFFFF, "R1");
    rd(6'h04, 32'h0, "R1");
    rd(6'h10, 32'h0, "R1");
    // R2 only run and div bits kept
    wr(6'h00, 32'hFFFFFFF9);
    rd(6'h00, {ID, 24'h000009}, "R2");
    wr(6'h00, 32'h4);
    // R3 event selection
    wr(6'h0C, 32'hFF140503);
    wr(6'h00, 32'h1);
    pulse(12'(1 << 3), 5);
    pulse(12'(1 << 5), 2);
    pulse(12'hFFF, 3);
    wr(6'h00, 32'h0);
    rd(6'h14, 32'd8, "R3");
    rd(6'h18, 32'd5, "R3");
    rd(6'h1C, 32'd0, "R3");
    rd(6'h20, 32'd0, "R3");
    // R4 normal mode
    wr(6'h00, 32'h4);
    wr(6'h00, 32'h1);
    idle(10);
    wr(6'h00, 32'h0);
    rd(6'h10, 32'd11, "R4");
    // R4 divided mode
    wr(6'h00, 32'h4);
    wr(6'h00, 32'h9);
    idle(20);
    wr(6'h00, 32'h0);
    rd(6'h10, 32'd2, "R4");
    // R5 event clear leaves cycle counter
    wr(6'h00, 32'h2);
    rd(6'h14, 32'd0, "R5");
    rd(6'h18, 32'd0, "R5");
    rd(6'h10, 32'd2, "R5");
    rd(6'h00, {ID, 24'h0}, "R5");
    // R6 cycle wrap, R8 interrupt
    wr(6'h08, 32'h1F);
    wr(6'h10, 32'hFFFFFFFE);
    wr(6'h00, 32'h1);
    idle(3);
    wr(6'h00, 32'h0);
    rd(6'h04, 32'h1, "R6");
    rd(6'h10, 32'd2, "R6");
    chk_irq(1'b1, "R8");
    // R6 event counter 2 wrap
    wr(6'h0C, 32'hFF070503);
    wr(6'h1C, 32'hFFFFFFFF);
    wr(6'h00, 32'h1);
    pulse(12'(1 << 7), 1);
    wr(6'h00, 32'h0);
    rd(6'h04, 32'h9, "R6");
    rd(6'h1C, 32'h0, "R6");
    // R7 write-one-to-clear
    wr(6'h04, 32'h1);
    rd(6'h04, 32'h8, "R7");
    chk_irq(1'b1, "R8");
    wr(6'h08, 32'h1);
    idle(1);
    chk_irq(1'b0, "R8");
    wr(6'h04, 32'h8);
    rd(6'h04, 32'h0, "R7");
    // R7 wrap on the clearing edge, R9 write beats increment
    wr(6'h00, 32'h1);
    wr(6'h10, 32'hFFFFFFFF);
    wr(6'h04, 32'h1);
    wr(6'h00, 32'h0);
    rd(6'h04, 32'h1, "R7");
    rd(6'h10, 32'd1, "R9");
    // R10 unmapped address
    wr(6'h3C, 32'hFFFFFFFF);
    rd(6'h3C, 32'h0, "R10");
    rd(6'h08, 32'h1, "R10");
    rd(6'h0C, 32'hFF070503, "R10");
    idle(2);
    finish_up();
  end
endmodule